// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block keeps the bookkeeping side of a set-associative cache with 64-byte lines. It takes a stream of accesses, each a read/write flag and a 64-bit byte address offered with a valid/ready handshake. For each access it decides hit or miss and, on a miss, picks the way to refill. It keeps the valid, tag, dirty and replacement-order state for every set. It holds no line data and drives no real memory port. It counts the memory traffic that a real cache would generate.

The number of sets and ways are parameters. The replacement policy (least-recently-used or first-in-first-out) and the write policy (write-through or write-back) are sampled from two configuration pins while reset is high and stay fixed until the next reset. Four 64-bit counters report hits, misses, line fetches from memory and writes to memory. The miss ratio is miss_cnt divided by (hit_cnt + miss_cnt). A synchronous clear input empties the cache and zeroes the counters without a reset.

Top module: `cache_tag_ctrl`

## Requirements
- R1: After reset, and after a cycle with clr high, all four counters read zero and every line is invalid, so the first access to any address misses.
- R2: Address bits [5:0] are a byte offset and play no part in the lookup. The set is (address >> 6) modulo SETS, so two addresses in one 64-byte line hit the same entry.
- R3: The stored tag is the whole block address (address >> 6, 58 bits). Addresses that differ only in bit 63 are distinct lines.
- R4: Every miss, read or write, fills a line and adds one to mem_rd_cnt. A hit leaves mem_rd_cnt unchanged. An invalid way is always filled before a valid way is evicted, so WAYS distinct lines of one set all stay resident.
- R5: With cfg_repl = 0 (LRU), a hit makes its way the most recent, and the evicted way is the least recently accessed one.
- R6: With cfg_repl = 1 (FIFO), hits do not change the order, and the evicted way is the one filled earliest.
- R7: With cfg_wpol = 0 (write-through), every accepted write adds one to mem_wr_cnt, hit or miss. No other event adds to it.
- R8: With cfg_wpol = 1 (write-back), a write marks its line dirty. Evicting a dirty line adds one to mem_wr_cnt. Clean evictions and write hits add nothing.
- R9: resp_valid is high in the cycle after each accepted access and low otherwise. resp_hit gives that access's result in the same cycle, and the counters have already been updated by then.
- R10: cfg_repl and cfg_wpol are sampled only while rst is high. Changing them later has no effect.
- R11: req_ready is low during reset and in any cycle with clr high. A clr cycle accepts no access.
- R12: Each accepted access adds exactly one to hit_cnt or to miss_cnt, never to both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; samples the configuration pins |
| clr | input | 1 | Synchronous clear of the counters and all valid bits |
| cfg_repl | input | 1 | Replacement policy: 0 LRU, 1 FIFO (sampled in reset) |
| cfg_wpol | input | 1 | Write policy: 0 write-through, 1 write-back (sampled in reset) |
| req_valid | input | 1 | An access is offered |
| req_ready | output | 1 | The block can take an access this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address of the access |
| resp_valid | output | 1 | Result of the previous cycle's accepted access |
| resp_hit | output | 1 | That access hit |
| hit_cnt | output | 64 | Accesses that hit |
| miss_cnt | output | 64 | Accesses that missed |
| mem_rd_cnt | output | 64 | Line fetches from memory |
| mem_wr_cnt | output | 64 | Writes to memory |

## Verification
Every result appears one clock edge after the accepting edge. resp_valid, resp_hit and all four counters change together at that edge, and req_ready follows clr in the same cycle. The bench runs a behavioural model with one queue per set. The model updates at the same edge where the design accepts an access. Outputs are compared 3 ns after every rising edge, when both sides have settled and before the next input change at the falling edge. Directed sequences then read resp_hit and the counters at the falling edge after the access, naming the ordering or write-policy case that each one exercises.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  localparam int LINE_OFF_W = 6;   // 64-byte lines

  typedef enum logic {
    REPL_LRU  = 1'b0,
    REPL_FIFO = 1'b1
  } repl_e;

  typedef enum logic {
    WPOL_THROUGH = 1'b0,
    WPOL_BACK    = 1'b1
  } wpol_e;
endpackage

// File: rtl/ctag_lookup.sv
// Tag compare across the ways of one set and victim choice.
module ctag_lookup #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 58,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]             valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags,
  input  logic [WAYS-1:0][WAY_W-1:0]  ages,
  input  logic [TAG_W-1:0]            tag,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way,
  output logic [WAY_W-1:0]            victim,
  output logic                        victim_live
);
  logic [WAYS-1:0] match;

  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
      assign match[g] = valid[g] && (tags[g] == tag);
    end
  endgenerate

  always_comb begin
    hit     = |match;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
    // oldest valid way by default, lowest invalid way takes precedence
    victim      = '0;
    victim_live = 1'b1;
    for (int w = 0; w < WAYS; w++) begin
      if (ages[w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) begin
        victim      = WAY_W'(w);
        victim_live = 1'b0;
      end
    end
  end
endmodule

// File: rtl/ctag_age.sv
// Rank update: the touched way becomes 0, younger ways age by one.
module ctag_age #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0][WAY_W-1:0] cur,
  input  logic                       touch,
  input  logic [WAY_W-1:0]           way,
  output logic [WAYS-1:0][WAY_W-1:0] nxt
);
  logic [WAY_W-1:0] pivot;

  always_comb begin
    pivot = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == way) pivot = cur[w];
    end
    for (int w = 0; w < WAYS; w++) begin
      if (!touch)                  nxt[w] = cur[w];
      else if (WAY_W'(w) == way)   nxt[w] = '0;
      else if (cur[w] < pivot)     nxt[w] = cur[w] + 1'b1;
      else                         nxt[w] = cur[w];
    end
  end
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
  import cache_tag_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cfg_repl,
  input  logic              cfg_wpol,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [63:0]       hit_cnt,
  output logic [63:0]       miss_cnt,
  output logic [63:0]       mem_rd_cnt,
  output logic [63:0]       mem_wr_cnt
);
  localparam int TAG_W = ADDR_W - LINE_OFF_W;
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  // latched configuration
  repl_e repl_q;
  wpol_e wpol_q;
  logic  wb_q;
  logic  ready_q;

  // per-set state
  logic [WAYS-1:0]            valid_q [SETS];
  logic [WAYS-1:0]            dirty_q [SETS];
  logic [WAYS-1:0][WAY_W-1:0] age_q   [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];

  logic              resp_valid_q, resp_hit_q;
  logic [63:0]       hit_q, miss_q, rd_q, wr_q;

  // request decode
  logic              accept;
  logic [TAG_W-1:0]  blk;
  logic [IDX_W-1:0]  set_idx;

  assign req_ready = ready_q & ~clr;
  assign accept    = req_valid & req_ready;
  assign blk       = req_addr[ADDR_W-1:LINE_OFF_W];
  assign set_idx   = IDX_W'(blk % TAG_W'(SETS));
  assign wb_q      = (wpol_q == WPOL_BACK);

  // lookup of the addressed set
  logic                       hit, victim_live;
  logic [WAY_W-1:0]           hit_way, victim;
  logic [WAYS-1:0]            set_valid, set_dirty;
  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  logic [WAYS-1:0][WAY_W-1:0] set_ages, set_ages_nxt;

  assign set_valid = valid_q[set_idx];
  assign set_dirty = dirty_q[set_idx];
  assign set_tags  = tag_q[set_idx];
  assign set_ages  = age_q[set_idx];

  ctag_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lookup (
    .valid       (set_valid),
    .tags        (set_tags),
    .ages        (set_ages),
    .tag         (blk),
    .hit         (hit),
    .hit_way     (hit_way),
    .victim      (victim),
    .victim_live (victim_live)
  );

  // order update: fills always, hits only under LRU
  logic             touch;
  logic [WAY_W-1:0] touch_way;
  assign touch     = hit ? (repl_q == REPL_LRU) : 1'b1;
  assign touch_way = hit ? hit_way : victim;

  ctag_age #(.WAYS(WAYS), .WAY_W(WAY_W)) u_age (
    .cur   (set_ages),
    .touch (touch),
    .way   (touch_way),
    .nxt   (set_ages_nxt)
  );

  // memory traffic of this access
  logic victim_dirty, wr_event;
  always_comb begin
    victim_dirty = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == victim) victim_dirty = set_dirty[w];
    end
    wr_event = wb_q ? (!hit && victim_live && victim_dirty) : req_write;
  end

  // configuration and handshake
  always_ff @(posedge clk) begin
    if (rst) begin
      repl_q  <= repl_e'(cfg_repl);
      wpol_q  <= wpol_e'(cfg_wpol);
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b1;
    end
  end

  // valid, dirty, order and counters
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      hit_q  <= '0;
      miss_q <= '0;
      rd_q   <= '0;
      wr_q   <= '0;
    end else begin
      resp_valid_q <= accept;
      if (accept) begin
        resp_hit_q     <= hit;
        age_q[set_idx] <= set_ages_nxt;
        if (hit) begin
          hit_q <= hit_q + 64'd1;
          if (req_write && wb_q) dirty_q[set_idx][hit_way] <= 1'b1;
        end else begin
          miss_q <= miss_q + 64'd1;
          rd_q   <= rd_q + 64'd1;
          valid_q[set_idx][victim] <= 1'b1;
          dirty_q[set_idx][victim] <= req_write && wb_q;
        end
        if (wr_event) wr_q <= wr_q + 64'd1;
      end
    end
  end

  // tag storage: written on fills only, no reset
  always_ff @(posedge clk) begin
    if (accept && !hit) tag_q[set_idx][victim] <= blk;
  end

  assign resp_valid = resp_valid_q;
  assign resp_hit   = resp_hit_q;
  assign hit_cnt    = hit_q;
  assign miss_cnt   = miss_q;
  assign mem_rd_cnt = rd_q;
  assign mem_wr_cnt = wr_q;
endmodule

// File: rtl/ctag_checker.sv
module ctag_checker (
  input logic        clk,
  input logic        rst,
  input logic        clr,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic        resp_valid,
  input logic        resp_hit,
  input logic        wb_mode,
  input logic [63:0] hit_cnt,
  input logic [63:0] miss_cnt,
  input logic [63:0] mem_rd_cnt,
  input logic [63:0] mem_wr_cnt
);
  logic acc;
  assign acc = req_valid && req_ready;

  // R9
  resp_follows_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> resp_valid);

  // R9
  resp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !resp_valid);

  // R11
  clr_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    clr |-> !req_ready);

  // R1
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (hit_cnt == 64'd0 && miss_cnt == 64'd0 &&
             mem_rd_cnt == 64'd0 && mem_wr_cnt == 64'd0));

  // R12
  one_count_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> (hit_cnt + miss_cnt) == ($past(hit_cnt) + $past(miss_cnt) + 64'd1));

  // R4
  miss_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_hit) |-> mem_rd_cnt == $past(mem_rd_cnt) + 64'd1);

  // R4
  hit_nofetch_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_hit) |-> $stable(mem_rd_cnt));

  // R7
  wt_write_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !wb_mode && $past(req_write)) |->
      mem_wr_cnt == $past(mem_wr_cnt) + 64'd1);

  // R8
  wb_hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_hit && wb_mode) |-> $stable(mem_wr_cnt));
endmodule

bind cache_tag_ctrl ctag_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr        (clr),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .resp_valid (resp_valid),
  .resp_hit   (resp_hit),
  .wb_mode    (wb_q),
  .hit_cnt    (hit_cnt),
  .miss_cnt   (miss_cnt),
  .mem_rd_cnt (mem_rd_cnt),
  .mem_wr_cnt (mem_wr_cnt)
);

// File: tb/cache_tag_ctrl_test.sv
`timescale 1ns/1ps
module cache_tag_ctrl_test;
  localparam int SETS = 16;
  localparam int WAYS = 4;
  localparam longint unsigned STRIDE = SETS * 64;

  logic        clk = 1'b0;
  logic        rst, clr, cfg_repl, cfg_wpol;
  logic        req_valid, req_write;
  logic        req_ready, resp_valid, resp_hit;
  logic [63:0] req_addr;
  logic [63:0] hit_cnt, miss_cnt, mem_rd_cnt, mem_wr_cnt;

  always #5 clk = ~clk;

  cache_tag_ctrl #(.SETS(SETS), .WAYS(WAYS), .ADDR_W(64)) uut (
    .clk(clk), .rst(rst), .clr(clr), .cfg_repl(cfg_repl), .cfg_wpol(cfg_wpol),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .hit_cnt(hit_cnt), .miss_cnt(miss_cnt), .mem_rd_cnt(mem_rd_cnt),
    .mem_wr_cnt(mem_wr_cnt)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct {
    logic [57:0] tag;
    bit          dirty;
  } line_t;

  line_t            mq [SETS][$];
  longint unsigned  e_hit, e_miss, e_rd, e_wr;
  bit               e_rv, e_rh, m_fifo, m_wb, m_ready;

  always @(posedge clk) begin
    if (rst) begin
      m_fifo = cfg_repl;
      m_wb   = cfg_wpol;
      m_ready = 1'b0;
      for (int s = 0; s < SETS; s++) mq[s].delete();
      e_hit = 0; e_miss = 0; e_rd = 0; e_wr = 0; e_rv = 0; e_rh = 0;
    end else if (clr) begin
      m_ready = 1'b1;
      for (int s = 0; s < SETS; s++) mq[s].delete();
      e_hit = 0; e_miss = 0; e_rd = 0; e_wr = 0; e_rv = 0; e_rh = 0;
    end else begin
      bit acc;
      acc  = req_valid && m_ready;
      e_rv = acc;
      m_ready = 1'b1;
      if (acc) begin
        logic [57:0] t;
        int s, idx;
        line_t ln;
        t   = req_addr[63:6];
        s   = int'(t % SETS);
        idx = -1;
        for (int i = 0; i < mq[s].size(); i++) if (mq[s][i].tag == t) idx = i;
        if (idx >= 0) begin
          e_rh = 1; e_hit++;
          ln = mq[s][idx];
          if (req_write && m_wb) ln.dirty = 1;
          if (m_fifo) mq[s][idx] = ln;
          else begin mq[s].delete(idx); mq[s].push_back(ln); end
        end else begin
          e_rh = 0; e_miss++; e_rd++;
          if (mq[s].size() == WAYS) begin
            ln = mq[s].pop_front();
            if (m_wb && ln.dirty) e_wr++;
          end
          ln.tag = t; ln.dirty = req_write && m_wb;
          mq[s].push_back(ln);
        end
        if (!m_wb && req_write) e_wr++;
      end
    end
  end

  // per-cycle comparison, 3 ns after each rising edge
  always @(posedge clk) begin
    #3;
    if (!rst) begin
      check(resp_valid == e_rv, "R9 resp_valid", resp_valid, e_rv);
      if (e_rv) check(resp_hit == e_rh, "R9 resp_hit", resp_hit, e_rh);
      check(req_ready == (m_ready && !clr), "R11 req_ready", req_ready, m_ready && !clr);
      check(hit_cnt == e_hit, "R12 hit_cnt", hit_cnt, e_hit);
      check(miss_cnt == e_miss, "R12 miss_cnt", miss_cnt, e_miss);
      check(mem_rd_cnt == e_rd, "R4 mem_rd_cnt", mem_rd_cnt, e_rd);
      check(mem_wr_cnt == e_wr, m_wb ? "R8 mem_wr_cnt" : "R7 mem_wr_cnt", mem_wr_cnt, e_wr);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_reset(input bit repl, input bit wpol);
    @(negedge clk);
    rst = 1; clr = 0; req_valid = 0; req_write = 0; req_addr = '0;
    cfg_repl = repl; cfg_wpol = wpol;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  // one access, result read at the next falling edge
  task automatic access(input bit wr, input logic [63:0] a, input bit exp_hit,
                        input string req);
    req_valid = 1; req_write = wr; req_addr = a;
    @(negedge clk);
    check(resp_valid && resp_hit == exp_hit, req, resp_hit, exp_hit);
    req_valid = 0;
  endtask

  task automatic expect_wr(input longint unsigned exp, input string req);
    check(mem_wr_cnt == exp, req, mem_wr_cnt, exp);
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      int r;
      r = $urandom_range(0, 99);
      req_valid = (r < 85);
      req_write = $urandom_range(0, 2) == 0;
      req_addr  = {($urandom_range(0, 9) == 0), 57'd0, 6'd0}
                | (64'($urandom_range(0, 7)) * STRIDE)
                | (64'($urandom_range(0, SETS - 1)) << 6)
                | 64'($urandom_range(0, 63));
      clr = (r == 99);
      @(negedge clk);
    end
    req_valid = 0; clr = 0;
    @(negedge clk);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    rst = 1; clr = 0; cfg_repl = 0; cfg_wpol = 0;
    req_valid = 0; req_write = 0; req_addr = '0;
    for (int p = 0; p < 4; p++) begin
      bit rp, wp;
      rp = p[0]; wp = p[1];
      do_reset(rp, wp);
      // R1 counters clear after reset
      check(hit_cnt == 0 && miss_cnt == 0 && mem_rd_cnt == 0 && mem_wr_cnt == 0,
            "R1 counters after reset", hit_cnt + miss_cnt + mem_rd_cnt + mem_wr_cnt, 0);
      access(0, 64'h0, 0, "R1 first access misses");
      access(0, 64'h3F, 1, "R2 offset ignored");
      access(0, 64'h40, 0, "R2 next line other set");
      access(0, 64'h8000_0000_0000_0000, 0, "R3 bit 63 distinct");
      access(0, 64'h0, 1, "R3 original still resident");

      // R10: flip the configuration pins after reset
      do_reset(rp, wp);
      cfg_repl = ~rp; cfg_wpol = ~wp;
      for (int i = 0; i < WAYS; i++) access(0, 64'(i) * STRIDE, 0, "R4 fill");
      for (int i = 0; i < WAYS; i++) access(0, 64'(i) * STRIDE, 1, "R4 invalid ways used first");
      access(0, 64'h0, 1, "R4 refresh line 0");
      access(0, 64'(WAYS) * STRIDE, 0, "R4 fifth line misses");
      // LRU keeps line 0 (recently used), FIFO dropped it (filled first)
      access(0, 64'h0, !rp, rp ? "R6 FIFO evicts oldest fill (R10)" : "R5 LRU keeps recent (R10)");

      // write policy
      do_reset(rp, wp);
      access(1, 64'h0, 0, "R8 write miss");
      access(1, 64'h0, 1, "R8 write hit");
      expect_wr(wp ? 0 : 2, wp ? "R8 no traffic before eviction" : "R7 one write per store");
      for (int i = 1; i < WAYS; i++) access(0, 64'(i) * STRIDE, 0, "R8 fill");
      access(0, 64'(WAYS) * STRIDE, 0, "R8 evict line 0");
      expect_wr(wp ? 1 : 2, wp ? "R8 dirty eviction writes" : "R7 reads add no writes");
      access(0, 64'(WAYS + 1) * STRIDE, 0, "R8 evict clean line");
      expect_wr(wp ? 1 : 2, wp ? "R8 clean eviction silent" : "R7 clean eviction silent");

      // R11 clear
      clr = 1;
      @(negedge clk);
      clr = 0;
      check(hit_cnt == 0 && miss_cnt == 0 && mem_rd_cnt == 0 && mem_wr_cnt == 0,
            "R11 counters after clr", hit_cnt + miss_cnt + mem_rd_cnt + mem_wr_cnt, 0);
      access(0, 64'(WAYS + 1) * STRIDE, 0, "R11 lines invalid after clr");

      random_run(2500);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule